// File: doc/BRIEF.md
# Wake-up Capture Controller

This block keeps watch over a bank of interrupt lines while the main interrupt controller is powered down. Each line has three configuration bits: a mask, a polarity and a sensitivity. Lines that are enabled and unmasked latch their events into a status vector. When the main controller wakes again, software can replay the latched events through a flush strobe, which briefly drives the masked status vector onto a pending output.

Every configuration array has a read view and two write aliases. One alias sets bits where a 1 is written and the other clears them. A write-one-to-clear acknowledge register clears status bits. A control word enables capture, can force all lines to edge detection, requests a flush and issues a software reset of the status. The register bus is 32 bits wide and uses word addresses. The number of lines is a parameter.

Top module: `wakeup_capture`

## Requirements
- R1: After reset all lines are masked (mask 1 = masked). Polarity, sensitivity and status read 0, the control word reads 0, `flush_o` is 0 and `pending_o` is 0.
- R2: The word address splits as group = `bus_addr[9:5]` and word = `bus_addr[4:0]`. Word n of a group covers lines 32n..32n+31, and bit (line mod 32) selects the line. The groups are: status 0, acknowledge 1, mask 2, mask-set 3, mask-clear 4, sensitivity 5, sensitivity-set 6, sensitivity-clear 7, polarity 8, polarity-set 9, polarity-clear 10, control 12. Unused groups, words past the line count and bits above the last line all read 0.
- R3: A 1 written to a set alias sets that line's bit, and a 1 written to a clear alias clears it. Zero bits leave the line unchanged. Writes to the read views of mask, sensitivity, polarity and status have no effect.
- R4: Polarity 1 makes a line active high, or rising for edge detection. Polarity 0 makes it active low, or falling.
- R5: Sensitivity 0 selects edge detection, which latches once per transition into the active level. Sensitivity 1 selects level detection, which latches again after an acknowledge while the line stays at its active level.
- R6: Control bit 1 (edge-only) forces every line to edge detection, whatever its sensitivity bit says.
- R7: Status bits latch only while control bit 0 (enable) is 1 and the line's mask bit is 0.
- R8: Writing 1 to a bit of the acknowledge group clears that line's status bit.
- R9: Writing 1 to control bit 2 raises `flush_o` for exactly one cycle, starting the cycle after the write. During that cycle `pending_o` equals status AND NOT mask. At all other times `pending_o` is 0.
- R10: Writing 1 to control bit 20 clears every status bit two clock edges after the write. The bit clears itself and always reads 0.
- R11: Control bit 31 reads as the OR of all unmasked status bits. Bits 0 and 1 read back as last written.
- R12: Inputs pass through a two-stage synchronizer. A line change is not visible in status at the first clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Asynchronous interrupt lines |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (group and word) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| pending_o | output | NUM_LINES | Masked status during a flush strobe, otherwise 0 |
| flush_o | output | 1 | One-cycle flush strobe |

## Verification
The assertions assume that bus accesses last exactly one cycle. They also assume that control writes reach the block only through the bus, so every flush strobe and every status clear can be traced back to a bus write. The latching check assumes that configuration changes only at clock edges. The stimulus drives the bus and `irq_in` only on falling clock edges, holds each access for a single cycle, and keeps every line stable for several cycles so that each change passes the synchronizer before the next one arrives.

// File: rtl/wuc_pkg.sv
package wuc_pkg;
    typedef enum logic [4:0] {
        GRP_STAT = 5'd0,
        GRP_ACK  = 5'd1,
        GRP_MASK = 5'd2,
        GRP_MSET = 5'd3,
        GRP_MCLR = 5'd4,
        GRP_SENS = 5'd5,
        GRP_SSET = 5'd6,
        GRP_SCLR = 5'd7,
        GRP_POL  = 5'd8,
        GRP_PSET = 5'd9,
        GRP_PCLR = 5'd10,
        GRP_CTRL = 5'd12
    } grp_e;

    localparam int CTRL_EN    = 0;
    localparam int CTRL_EDGE  = 1;
    localparam int CTRL_FLUSH = 2;
    localparam int CTRL_SWRST = 20;
    localparam int CTRL_EVENT = 31;
    localparam int WORD_BITS  = 32;
endpackage

// File: rtl/wuc_sync.sv
module wuc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/wuc_detect.sv
module wuc_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] sens_i,
    input  logic         edge_only_i,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] prev_d, prev_q;
    logic [W-1:0] act_now, act_prev;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_line
        assign act_now[g]  = lvl_i[g] ~^ pol_i[g];
        assign act_prev[g] = prev_q[g] ~^ pol_i[g];
        assign hit_o[g]    = (edge_only_i | ~sens_i[g]) ? (act_now[g] & ~act_prev[g])
                                                         : act_now[g];
    end

    // R6
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_only_i |-> ((hit_o & ~(lvl_i ^ prev_q)) == '0));
endmodule

// File: rtl/wuc_regfile.sv
module wuc_regfile
    import wuc_pkg::*;
#(
    parameter int NUM_LINES = 439
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [9:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic [NUM_LINES-1:0] hit_i,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] pol_o,
    output logic [NUM_LINES-1:0] sens_o,
    output logic                 edge_only_o,
    output logic [NUM_LINES-1:0] pending_o,
    output logic                 flush_o
);
    localparam int NUM_WORDS = (NUM_LINES + WORD_BITS - 1) / WORD_BITS;
    localparam int PADW      = NUM_WORDS * WORD_BITS;

    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] pol;
        logic [NUM_LINES-1:0] sens;
        logic [NUM_LINES-1:0] status;
        logic                 en;
        logic                 edge_only;
        logic                 flush;
        logic                 swrst;
        logic [31:0]          rdata;
    } reg_t;

    reg_t s_d, s_q;

    logic [4:0]           grp;
    logic [4:0]           widx;
    logic                 wr;
    logic                 word_ok;
    logic [NUM_LINES-1:0] wbits;
    logic [NUM_LINES-1:0] ack_bits;
    logic [NUM_LINES-1:0] live;
    logic [PADW-1:0]      view;
    logic [31:0]          rword;

    always_comb begin
        grp     = bus_addr[9:5];
        widx    = bus_addr[4:0];
        wr      = bus_sel & bus_wr;
        word_ok = (32'(widx) < NUM_WORDS);
        for (int i = 0; i < NUM_LINES; i++) begin
            wbits[i] = wr && word_ok && (widx == 5'(i / WORD_BITS)) && bus_wdata[i % WORD_BITS];
        end
        live = s_q.status & ~s_q.mask;

        // configuration and control writes
        s_d       = s_q;
        s_d.flush = 1'b0;
        s_d.swrst = 1'b0;
        ack_bits  = '0;
        case (grp)
            GRP_MSET: s_d.mask = s_q.mask | wbits;
            GRP_MCLR: s_d.mask = s_q.mask & ~wbits;
            GRP_SSET: s_d.sens = s_q.sens | wbits;
            GRP_SCLR: s_d.sens = s_q.sens & ~wbits;
            GRP_PSET: s_d.pol  = s_q.pol | wbits;
            GRP_PCLR: s_d.pol  = s_q.pol & ~wbits;
            GRP_ACK:  ack_bits = wbits;
            GRP_CTRL: if (wr) begin
                s_d.en        = bus_wdata[CTRL_EN];
                s_d.edge_only = bus_wdata[CTRL_EDGE];
                s_d.flush     = bus_wdata[CTRL_FLUSH];
                s_d.swrst     = bus_wdata[CTRL_SWRST];
            end
            default: ;
        endcase

        // status latch: a new event wins over an acknowledge in the same cycle
        if (s_q.swrst) s_d.status = '0;
        else s_d.status = (s_q.status & ~ack_bits)
                        | (hit_i & ~s_q.mask & {NUM_LINES{s_q.en}});

        // read mux
        case (grp)
            GRP_STAT: view = PADW'(s_q.status);
            GRP_MASK: view = PADW'(s_q.mask);
            GRP_SENS: view = PADW'(s_q.sens);
            GRP_POL:  view = PADW'(s_q.pol);
            default:  view = '0;
        endcase
        rword = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (widx == 5'(w)) rword = view[w*WORD_BITS +: WORD_BITS];
        end
        if (grp == GRP_CTRL) begin
            rword             = '0;
            rword[CTRL_EN]    = s_q.en;
            rword[CTRL_EDGE]  = s_q.edge_only;
            rword[CTRL_EVENT] = |live;
        end
        if (bus_sel && !bus_wr) s_d.rdata = rword;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mask <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata   = s_q.rdata;
    assign pol_o       = s_q.pol;
    assign sens_o      = s_q.sens;
    assign edge_only_o = s_q.edge_only;
    assign flush_o     = s_q.flush;
    assign pending_o   = s_q.flush ? live : '0;

    // R7
    status_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((s_q.status & ~$past(s_q.status))
                   & ($past(s_q.mask) | {NUM_LINES{~$past(s_q.en)}})) == '0));

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && grp == GRP_MSET) |=> ((s_q.mask & $past(wbits)) == $past(wbits)));

    // R9
    flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(bus_sel && bus_wr && bus_addr[9:5] == GRP_CTRL && bus_wdata[CTRL_FLUSH]));

    // R10
    swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[9:5] == GRP_CTRL && bus_wdata[CTRL_SWRST])
            |=> ##1 (s_q.status == '0));
endmodule

// File: rtl/wakeup_capture.sv
module wakeup_capture #(
    parameter int NUM_LINES = 439
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [9:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] pending_o,
    output logic                 flush_o
);
    logic [NUM_LINES-1:0] irq_sync;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] pol;
    logic [NUM_LINES-1:0] sens;
    logic                 edge_only;

    wuc_sync #(.W(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .sync_o  (irq_sync)
    );

    wuc_detect #(.W(NUM_LINES)) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_i       (irq_sync),
        .pol_i       (pol),
        .sens_i      (sens),
        .edge_only_i (edge_only),
        .hit_o       (hit)
    );

    wuc_regfile #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .hit_i       (hit),
        .bus_rdata   (bus_rdata),
        .pol_o       (pol),
        .sens_o      (sens),
        .edge_only_o (edge_only),
        .pending_o   (pending_o),
        .flush_o     (flush_o)
    );
endmodule

// File: tb/wakeup_capture_tb.sv
module wakeup_capture_tb;
    localparam int NL = 40;
    localparam logic [9:0] A_STAT = 10'h000, A_ACK  = 10'h020, A_MASK = 10'h040,
                           A_MSET = 10'h060, A_MCLR = 10'h080, A_SENS = 10'h0A0,
                           A_SSET = 10'h0C0, A_SCLR = 10'h0E0, A_POL  = 10'h100,
                           A_PSET = 10'h120, A_PCLR = 10'h140, A_CTRL = 10'h180;
    localparam int NT = 24;
    // {read(1)/write(0), word address, data or expected value}
    localparam logic [42:0] TBL [NT] = '{
        {1'b1, A_MASK,     32'hFFFF_FFFF}, // R1
        {1'b1, A_MASK + 1, 32'h0000_00FF}, // R1 R2 bits above line 39 read 0
        {1'b1, A_POL,      32'h0},         // R1
        {1'b1, A_SENS + 1, 32'h0},         // R1
        {1'b1, A_CTRL,     32'h0},         // R1
        {1'b0, A_MCLR,     32'h0000_000F}, // R3
        {1'b1, A_MASK,     32'hFFFF_FFF0}, // R3 zero bits untouched
        {1'b0, A_MSET,     32'h0000_0003},
        {1'b1, A_MASK,     32'hFFFF_FFF3}, // R3
        {1'b0, A_SSET,     32'h0000_00A5},
        {1'b1, A_SENS,     32'h0000_00A5}, // R3
        {1'b0, A_SCLR,     32'h0000_0005},
        {1'b1, A_SENS,     32'h0000_00A0}, // R3
        {1'b0, A_PSET + 1, 32'h0000_0081},
        {1'b1, A_POL + 1,  32'h0000_0081}, // R2 word 1
        {1'b0, A_PCLR + 1, 32'hFFFF_FF01},
        {1'b1, A_POL + 1,  32'h0000_0080}, // R3
        {1'b0, A_MASK,     32'h0},         // R3 write to read view
        {1'b1, A_MASK,     32'hFFFF_FFF3}, // R3 unchanged
        {1'b1, 10'h1A0,    32'h0},         // R2 unused group
        {1'b1, A_MASK + 2, 32'h0},         // R2 word past line count
        {1'b0, A_CTRL,     32'h0000_0003},
        {1'b1, A_CTRL,     32'h0000_0003}, // R11
        {1'b1, A_STAT,     32'h0}          // R6 R7
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pending_o;
    logic          flush_o;
    int            n_chk = 0;
    int            n_bad = 0;
    logic [31:0]   rd;

    always #2 clk = ~clk;

    wakeup_capture #(.NUM_LINES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pending_o(pending_o), .flush_o(flush_o));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rd(input string req, input logic [9:0] a, input logic [31:0] e);
        bus_read(a, rd);
        check(req, 64'(rd), 64'(e));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flush_o", 64'(flush_o), 64'd0);
        check("R1 pending_o", 64'(pending_o), 64'd0);

        for (int k = 0; k < NT; k++) begin
            if (TBL[k][42]) expect_rd($sformatf("R1-table step %0d", k), TBL[k][41:32], TBL[k][31:0]);
            else            bus_write(TBL[k][41:32], TBL[k][31:0]);
        end

        // R12 and R4: line 2 rising, line 3 falling
        bus_write(A_PSET, 32'h4);
        irq_in[2] = 1'b1; irq_in[3] = 1'b1;
        expect_rd("R12 not visible yet", A_STAT, 32'h0);
        idle(4);
        expect_rd("R4 rising latched", A_STAT, 32'h4);
        irq_in[3] = 1'b0;
        idle(4);
        expect_rd("R4 falling latched", A_STAT, 32'hC);
        expect_rd("R11 event bit", A_CTRL, 32'h8000_0003);

        // R8 acknowledge, edge line does not relatch
        bus_write(A_ACK, 32'h4);
        idle(4);
        expect_rd("R8 ack clears one", A_STAT, 32'h8);
        bus_write(A_ACK, 32'h8);
        expect_rd("R8 ack clears all", A_STAT, 32'h0);

        // R6 / R5 level line 5, active low, input low
        bus_write(A_MCLR, 32'h20);
        idle(4);
        expect_rd("R6 edge-only blocks level", A_STAT, 32'h0);
        bus_write(A_CTRL, 32'h1);
        idle(4);
        expect_rd("R5 level latched", A_STAT, 32'h20);
        bus_write(A_ACK, 32'h20);
        idle(2);
        expect_rd("R5 level relatches", A_STAT, 32'h20);
        irq_in[5] = 1'b1;
        idle(4);
        bus_write(A_ACK, 32'h20);
        idle(2);
        expect_rd("R5 inactive level stays clear", A_STAT, 32'h0);

        // R7 masked line 0 ignored
        irq_in[0] = 1'b1; idle(4); irq_in[0] = 1'b0; idle(4);
        expect_rd("R7 masked line", A_STAT, 32'h0);

        // R7 disabled capture
        bus_write(A_CTRL, 32'h0);
        irq_in[3] = 1'b1; idle(4); irq_in[3] = 1'b0; idle(4);
        expect_rd("R7 disabled", A_STAT, 32'h0);
        expect_rd("R11 no event", A_CTRL, 32'h0);

        // R9 flush with one masked status bit
        bus_write(A_CTRL, 32'h1);
        irq_in[3] = 1'b1; idle(4); irq_in[3] = 1'b0; idle(4);
        bus_write(A_MCLR + 1, 32'h2);
        irq_in[33] = 1'b1; idle(4); irq_in[33] = 1'b0; idle(4);
        bus_write(A_MSET, 32'h8);
        expect_rd("R9 raw status word0", A_STAT, 32'h8);
        expect_rd("R9 raw status word1", A_STAT + 1, 32'h2);
        bus_write(A_CTRL, 32'h5);
        check("R9 flush strobe", 64'(flush_o), 64'd1);
        check("R9 pending vector", 64'(pending_o), 64'h02_0000_0000);
        @(negedge clk);
        check("R9 strobe ends", 64'(flush_o), 64'd0);
        check("R9 pending cleared", 64'(pending_o), 64'd0);
        expect_rd("R11 unmasked only", A_CTRL, 32'h8000_0001);

        // R10 software reset
        bus_write(A_CTRL, 32'h0010_0001);
        idle(2);
        expect_rd("R10 status word1", A_STAT + 1, 32'h0);
        expect_rd("R10 status word0", A_STAT, 32'h0);
        expect_rd("R10 self-clear", A_CTRL, 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule